// File: doc/BRIEF.md
# Packet buffer page allocator

This block keeps the books for a shared packet memory that is cut into 256-byte pages. The memory itself sits elsewhere. A host drives a 16-bit command word. The command can claim a packet made of one or more pages, hand pages back, move packets through a transmit queue and a receive queue, or wipe the whole state at once. The receive engine has its own request port. Through that port it claims pages for an incoming frame, and each packet it claims goes onto the receive queue. The transmit engine takes packets off the head of the transmit queue.

Every packet gets a packet number, and each page records which packet owns it. Pages are taken from the lowest free positions, and packet numbers from the lowest free number. Handing back a packet is a walk over the page table, one page per clock, and a busy flag is raised while the walk runs. Receive-side claims must leave a configurable reserve of pages untouched, so that the transmit side can still get memory.

The host can read an allocation result byte, a queue-head word, a memory-count word and the busy flag. A single-cycle pulse signals a completed allocation.

Top module: `pktbuf_page_alloc`

## Requirements
- R1: Command bits 7:5 pick the operation: 0 none, 1 claim, 2 wipe, 3 drop receive head, 4 drop receive head and hand back its pages, 5 hand back packet `pnr`, 6 append `pnr` to the transmit queue, 7 empty the transmit queue. Operation 0 changes nothing, whatever the other bits hold.
- R2: A claim takes command bits 2:0 plus one pages, at the lowest free page positions. It gives the packet the lowest free packet number and writes `{1'b0, number}` into `alloc_result` on the next cycle.
- R3: A claim that finds too few free pages, or no free packet number, writes 8'h80 into `alloc_result` (bit 7 is the failure flag, bits 6:0 are zero) and changes no other state.
- R4: `alloc_int` is high for exactly the one cycle after a successful host claim, and is low otherwise.
- R5: `queue_heads` is {receive-empty, receive head[6:0], transmit-empty, transmit head[6:0]}. An empty queue shows a head of zero, so after a wipe the word reads 16'h8080.
- R6: `mem_info` carries the free page count in bits 15:8 and the total page count in bits 7:0.
- R7: Handing back a packet (operations 4 and 5) raises `busy` for exactly NUM_PAGES cycles, starting on the cycle after the command. After that the pages are free and the packet number can be reused. While `busy` is high, every command except the wipe is ignored and receive claims fail.
- R8: Operation 5 on a packet number that is not allocated is ignored. `busy` stays low and the counts do not change.
- R9: Operation 3 removes the receive head and keeps its pages allocated. Operation 4 removes the receive head and hands its pages back. Both are ignored when the receive queue is empty.
- R10: Operation 6 appends only allocated packets. `tx_pop` removes the transmit head without freeing its pages. Operation 7 empties the transmit queue only.
- R11: The wipe takes effect on the next cycle. All pages and packet numbers become free, both queues become empty and `busy` drops. `alloc_result` is kept.
- R12: A receive claim of `rx_size_m1`+1 pages succeeds only when the free page count is at least that size plus `tx_reserve`. On success it pulses `rx_alloc_ok` with the packet in `rx_alloc_pkt` and appends the packet to the receive queue. Host claims ignore the reserve. A receive claim that meets a host command other than operation 0 in the same cycle fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word is written this cycle |
| cmd_word | input | 16 | Command word: bits 7:5 operation, bits 2:0 page count minus one |
| pnr | input | 7 | Packet number used by operations 5 and 6 |
| tx_reserve | input | 5 | Pages kept back from receive claims |
| rx_req | input | 1 | Receive engine asks for pages |
| rx_size_m1 | input | SIZE_W | Pages wanted by the receive engine, minus one |
| tx_pop | input | 1 | Transmit engine takes the transmit head |
| alloc_result | output | 8 | Last host claim: failure flag and packet number |
| queue_heads | output | 16 | Queue heads and empty flags |
| mem_info | output | 16 | Free and total page counts |
| busy | output | 1 | Page hand-back in progress |
| alloc_int | output | 1 | Host claim completed |
| rx_alloc_ok | output | 1 | Receive claim granted |
| rx_alloc_pkt | output | 7 | Packet number of the granted receive claim |

## Verification
The bench targets the reserve boundary. A receive claim that fits only if the reserve is ignored must fail, while a host claim of the same pages must succeed. A design that applied the reserve to the wrong side would invert one of these two results. Repeated and unallocated hand-backs must leave the counts alone, so a design that blindly counted them would over-report free pages. The bench also checks that operation 3 keeps pages that operation 4 returns, that a claim after a hand-back reuses the lowest packet number, that the hand-back lasts exactly the expected number of busy cycles, and that a wipe during the walk cancels it at once. A design that only finished the walk would keep `busy` high after the wipe.

// File: rtl/pba_pkg.sv
package pba_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_CLAIM   = 3'd1,
      OP_WIPE    = 3'd2,
      OP_RX_DROP = 3'd3,
      OP_RX_FREE = 3'd4,
      OP_FREE    = 3'd5,
      OP_TX_PUSH = 3'd6,
      OP_TX_CLR  = 3'd7
   } pba_op_e;

   localparam int PN_W     = 7;
   localparam int FAIL_BIT = 7;
endpackage

// File: rtl/pba_queue.sv
module pba_queue #(
   parameter int DEPTH = 8,
   parameter int W     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("pba_queue: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rd_ptr, wr_ptr;
   logic [AW:0]   count;

   assign empty = (count == '0);
   assign full  = (count == (AW+1)'(DEPTH));
   assign head  = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   // R10: an accepted push leaves the queue non-empty
   a_r10_push_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr) |=> !empty);
   // R5: a pop on an empty queue never reaches here
   a_r5_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |-> !empty);
endmodule

// File: rtl/pba_pick.sv
module pba_pick #(
   parameter int N      = 16,
   parameter int NEED_W = 4,
   parameter int CNT_W  = 5
) (
   input  logic [N-1:0]      free_map,
   input  logic [NEED_W-1:0] need,
   output logic [N-1:0]      take_map,
   output logic [CNT_W-1:0]  free_cnt
);
   logic [15:0] taken;
   logic [15:0] ones;

   always_comb begin
      taken    = '0;
      take_map = '0;
      for (int i = 0; i < N; i++) begin
         if (free_map[i] && (taken < 16'(need))) begin
            take_map[i] = 1'b1;
            taken       = taken + 16'd1;
         end
      end
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < N; i++) ones = ones + 16'(free_map[i]);
   end
   assign free_cnt = CNT_W'(ones);
endmodule

// File: rtl/pba_lowest.sv
module pba_lowest #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic [N-1:0]  used,
   output logic [IW-1:0] idx,
   output logic          found
);
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!used[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pktbuf_page_alloc.sv
module pktbuf_page_alloc #(
   parameter int NUM_PAGES = 16,
   parameter int NUM_PKTS  = 8,
   parameter int SIZE_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [15:0]       cmd_word,
   input  logic [6:0]        pnr,
   input  logic [4:0]        tx_reserve,
   input  logic              rx_req,
   input  logic [SIZE_W-1:0] rx_size_m1,
   input  logic              tx_pop,
   output logic [7:0]        alloc_result,
   output logic [15:0]       queue_heads,
   output logic [15:0]       mem_info,
   output logic              busy,
   output logic              alloc_int,
   output logic              rx_alloc_ok,
   output logic [6:0]        rx_alloc_pkt
);
   import pba_pkg::*;

   localparam int PKT_IW = $clog2(NUM_PKTS);
   localparam int PG_IW  = $clog2(NUM_PAGES);
   localparam int CNT_W  = $clog2(NUM_PAGES + 1);
   localparam int NEED_W = SIZE_W + 1;

   generate
      if (NUM_PAGES < 2 || NUM_PAGES > 255) begin : g_bad_pages
         $error("pktbuf_page_alloc: NUM_PAGES must lie in 2..255");
      end
      if (NUM_PKTS < 2 || NUM_PKTS > 128 || (1 << PKT_IW) != NUM_PKTS) begin : g_bad_pkts
         $error("pktbuf_page_alloc: NUM_PKTS must be a power of two in 2..128");
      end
      if (SIZE_W < 1 || SIZE_W > 5) begin : g_bad_size
         $error("pktbuf_page_alloc: SIZE_W must lie in 1..5");
      end
   endgenerate

   // ---------------- state ----------------
   logic [NUM_PAGES-1:0] page_used;
   logic [PKT_IW-1:0]    page_own [NUM_PAGES];
   logic [NUM_PKTS-1:0]  pkt_used;
   logic                 rel_active;
   logic [PG_IW-1:0]     rel_idx;
   logic [PKT_IW-1:0]    rel_pkt;

   // ---------------- decode ----------------
   pba_op_e op;
   logic    do_wipe, act, pn_ok;
   logic [PKT_IW-1:0] pn_idx;

   assign op      = pba_op_e'(cmd_word[7:5]);
   assign do_wipe = cmd_valid && (op == OP_WIPE);
   assign act     = cmd_valid && !rel_active;
   assign pn_idx  = pnr[PKT_IW-1:0];
   assign pn_ok   = (pnr < PN_W'(NUM_PKTS)) && pkt_used[pn_idx];

   // ---------------- claim path ----------------
   logic              host_claim, rx_serve;
   logic [NEED_W-1:0] host_need, rx_need, need_sel;
   logic [NUM_PAGES-1:0] take_map;
   logic [CNT_W-1:0]  free_cnt;
   logic [PKT_IW-1:0] new_pkt;
   logic              pkt_avail;
   logic              host_fits, rx_fits, claim_host_go, claim_rx_go;

   assign host_claim = act && (op == OP_CLAIM);
   assign rx_serve   = rx_req && !rel_active && !(cmd_valid && (op != OP_NOP));
   assign host_need  = NEED_W'(cmd_word[SIZE_W-1:0]) + 1'b1;
   assign rx_need    = NEED_W'(rx_size_m1) + 1'b1;
   assign need_sel   = host_claim ? host_need : rx_need;

   pba_pick #(.N(NUM_PAGES), .NEED_W(NEED_W), .CNT_W(CNT_W)) i_pick (
      .free_map (~page_used),
      .need     (need_sel),
      .take_map (take_map),
      .free_cnt (free_cnt)
   );

   pba_lowest #(.N(NUM_PKTS), .IW(PKT_IW)) i_lowest (
      .used  (pkt_used),
      .idx   (new_pkt),
      .found (pkt_avail)
   );

   assign host_fits     = 16'(free_cnt) >= 16'(host_need);
   assign rx_fits       = 16'(free_cnt) >= (16'(rx_need) + 16'(tx_reserve));
   assign claim_host_go = host_claim && host_fits && pkt_avail;
   assign claim_rx_go   = rx_serve && rx_fits && pkt_avail;

   // ---------------- queues ----------------
   logic [PKT_IW-1:0] rxq_head, txq_head;
   logic rxq_empty, rxq_full, txq_empty, txq_full;
   logic rxq_pop, txq_push, txq_pop, txq_clr;

   assign rxq_pop  = act && ((op == OP_RX_DROP) || (op == OP_RX_FREE)) && !rxq_empty;
   assign txq_clr  = do_wipe || (act && (op == OP_TX_CLR));
   assign txq_push = act && (op == OP_TX_PUSH) && pn_ok && !txq_full;
   assign txq_pop  = tx_pop && !txq_empty && !txq_clr;

   pba_queue #(.DEPTH(NUM_PKTS), .W(PKT_IW)) i_rxq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (do_wipe),
      .push      (claim_rx_go && !rxq_full),
      .push_data (new_pkt),
      .pop       (rxq_pop),
      .head      (rxq_head),
      .empty     (rxq_empty),
      .full      (rxq_full)
   );

   pba_queue #(.DEPTH(NUM_PKTS), .W(PKT_IW)) i_txq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (txq_clr),
      .push      (txq_push),
      .push_data (pn_idx),
      .pop       (txq_pop),
      .head      (txq_head),
      .empty     (txq_empty),
      .full      (txq_full)
   );

   // ---------------- hand-back walker ----------------
   logic              rel_start, rel_last;
   logic [PKT_IW-1:0] rel_target;

   always_comb begin
      rel_start  = 1'b0;
      rel_target = pn_idx;
      if (act && (op == OP_RX_FREE) && !rxq_empty) begin
         rel_start  = 1'b1;
         rel_target = rxq_head;
      end else if (act && (op == OP_FREE) && pn_ok) begin
         rel_start  = 1'b1;
      end
   end

   assign rel_last = rel_active && (rel_idx == PG_IW'(NUM_PAGES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_active <= 1'b0;
         rel_idx    <= '0;
         rel_pkt    <= '0;
      end else if (do_wipe) begin
         rel_active <= 1'b0;
         rel_idx    <= '0;
      end else if (rel_start) begin
         rel_active <= 1'b1;
         rel_idx    <= '0;
         rel_pkt    <= rel_target;
      end else if (rel_active) begin
         rel_active <= !rel_last;
         rel_idx    <= rel_idx + 1'b1;
      end
   end

   // ---------------- page and packet tables ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_used <= '0;
         pkt_used  <= '0;
         for (int i = 0; i < NUM_PAGES; i++) page_own[i] <= '0;
      end else if (do_wipe) begin
         page_used <= '0;
         pkt_used  <= '0;
      end else begin
         if (claim_host_go || claim_rx_go) begin
            pkt_used[new_pkt] <= 1'b1;
            for (int i = 0; i < NUM_PAGES; i++) begin
               if (take_map[i]) begin
                  page_used[i] <= 1'b1;
                  page_own[i]  <= new_pkt;
               end
            end
         end
         if (rel_active && page_used[rel_idx] && (page_own[rel_idx] == rel_pkt))
            page_used[rel_idx] <= 1'b0;
         if (rel_last)
            pkt_used[rel_pkt] <= 1'b0;
      end
   end

   // ---------------- host-visible results ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_result <= '0;
         alloc_int    <= 1'b0;
         rx_alloc_ok  <= 1'b0;
         rx_alloc_pkt <= '0;
      end else begin
         alloc_int   <= claim_host_go;
         rx_alloc_ok <= claim_rx_go;
         if (claim_rx_go) rx_alloc_pkt <= PN_W'(new_pkt);
         if (host_claim)
            alloc_result <= claim_host_go ? {1'b0, PN_W'(new_pkt)} : 8'(1 << FAIL_BIT);
      end
   end

   assign busy        = rel_active;
   assign mem_info    = {8'(free_cnt), 8'(NUM_PAGES)};
   assign queue_heads = {rxq_empty, PN_W'(rxq_head), txq_empty, PN_W'(txq_head)};

   // ---------------- assertions ----------------
   // R11: the wipe completes in one cycle
   a_r11_wipe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word[7:5] == 3'd2) |=>
         (!busy && mem_info[15:8] == 8'(NUM_PAGES) && queue_heads[15] && queue_heads[7]));
   // R4: the completion pulse only follows a successful claim
   a_r4_int_success: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_int |-> !alloc_result[FAIL_BIT]);
   // R7: no claim is granted while the walker runs
   a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!alloc_int && !rx_alloc_ok));
   // R8: handing back an unallocated packet does nothing
   a_r8_free_unalloc: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_word[7:5] == 3'd5 && !busy && !pn_ok) |=> (!busy && $stable(mem_info)));
   // R12: a receive grant leaves the reserve in place
   a_r12_reserve_kept: assert property (@(posedge clk) disable iff (!rst_n)
      rx_alloc_ok |-> (16'(mem_info[15:8]) >= 16'($past(tx_reserve))));
endmodule

// File: tb/test_pktbuf_page_alloc.sv
`timescale 1ns/1ps
module test_pktbuf_page_alloc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [6:0]  pnr = '0;
   logic [4:0]  tx_reserve = 5'd4;
   logic        rx_req = 1'b0;
   logic [2:0]  rx_size_m1 = '0;
   logic        tx_pop = 1'b0;
   logic [7:0]  alloc_result;
   logic [15:0] queue_heads, mem_info;
   logic        busy, alloc_int, rx_alloc_ok;
   logic [6:0]  rx_alloc_pkt;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   pktbuf_page_alloc i_pktbuf_page_alloc (
      .clk, .rst_n, .cmd_valid, .cmd_word, .pnr, .tx_reserve, .rx_req,
      .rx_size_m1, .tx_pop, .alloc_result, .queue_heads, .mem_info, .busy,
      .alloc_int, .rx_alloc_ok, .rx_alloc_pkt
   );

   // {cmd[54:39], pnr[38:32], result[31:24], free[23:16], heads[15:0]}
   localparam int NV = 16;
   localparam logic [54:0] VEC [NV] = '{
      {16'h001F, 7'd0, 8'h00, 8'd16, 16'h8080},  // R1 op 0 with stray bits
      {16'h0021, 7'd0, 8'h00, 8'd14, 16'h8080},  // R2 two pages
      {16'h0023, 7'd0, 8'h01, 8'd10, 16'h8080},  // R2 four pages
      {16'h00C0, 7'd1, 8'h01, 8'd10, 16'h8001},  // R10 append 1
      {16'h00C0, 7'd0, 8'h01, 8'd10, 16'h8001},  // R10 append 0 behind 1
      {16'h0027, 7'd0, 8'h02, 8'd2,  16'h8001},  // R2 eight pages
      {16'h0022, 7'd0, 8'h80, 8'd2,  16'h8001},  // R3 too few pages
      {16'h00C0, 7'd6, 8'h80, 8'd2,  16'h8001},  // R10 unallocated ignored
      {16'h00E0, 7'd0, 8'h80, 8'd2,  16'h8080},  // R10 empty tx queue
      {16'h00A0, 7'd2, 8'h80, 8'd10, 16'h8080},  // R7 hand back 2
      {16'h00A0, 7'd2, 8'h80, 8'd10, 16'h8080},  // R8 again
      {16'h00A0, 7'd5, 8'h80, 8'd10, 16'h8080},  // R8 never claimed
      {16'h0027, 7'd0, 8'h02, 8'd2,  16'h8080},  // R7 number 2 reused
      {16'h0040, 7'd0, 8'h02, 8'd16, 16'h8080},  // R11 wipe keeps result
      {16'h0027, 7'd0, 8'h00, 8'd8,  16'h8080},  // R11 numbers free again
      {16'h0040, 7'd0, 8'h00, 8'd16, 16'h8080}   // R11 wipe
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [15:0] w, input logic [6:0] p);
      cmd_valid = 1'b1;
      cmd_word  = w;
      pnr       = p;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_word  = '0;
   endtask

   task automatic rx_claim(input logic [2:0] m1);
      rx_req     = 1'b1;
      rx_size_m1 = m1;
      @(negedge clk);
      rx_req     = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      check("R5 reset heads", 32'(queue_heads), 32'h8080);
      check("R6 reset mem_info", 32'(mem_info), 32'h1010);
      check("R7 reset busy", 32'(busy), 32'd0);
      check("R4 reset int", 32'(alloc_int), 32'd0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         cmd(VEC[v][54:39], VEC[v][38:32]);
         wait_idle(n);
         check($sformatf("R2 R3 vector %0d result", v), 32'(alloc_result), 32'(VEC[v][31:24]));
         check($sformatf("R6 vector %0d free", v), 32'(mem_info[15:8]), 32'(VEC[v][23:16]));
         check($sformatf("R5 vector %0d heads", v), 32'(queue_heads), 32'(VEC[v][15:0]));
      end
      check("R6 total", 32'(mem_info[7:0]), 32'd16);

      // R10: transmit pop does not free pages
      cmd(16'h0020, 7'd0);
      check("R4 int after claim", 32'(alloc_int), 32'd1);
      @(negedge clk);
      check("R4 int one cycle", 32'(alloc_int), 32'd0);
      cmd(16'h0020, 7'd0);
      cmd(16'h00C0, 7'd0);
      cmd(16'h00C0, 7'd1);
      check("R10 tx head 0", 32'(queue_heads), 32'h8000);
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
      check("R10 tx head after pop", 32'(queue_heads), 32'h8001);
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
      check("R10 tx empty after pops", 32'(queue_heads), 32'h8080);
      check("R10 pop keeps pages", 32'(mem_info[15:8]), 32'd14);
      cmd(16'h0040, 7'd0);

      // R12: receive claims and the reserve (tx_reserve = 4)
      rx_claim(3'd7);
      check("R12 rx ok 8 pages", 32'(rx_alloc_ok), 32'd1);
      check("R12 rx pkt", 32'(rx_alloc_pkt), 32'd0);
      check("R12 rx queued", 32'(queue_heads), 32'h0080);
      rx_claim(3'd3);
      check("R12 rx ok at reserve edge", 32'(rx_alloc_ok), 32'd1);
      check("R12 free 4", 32'(mem_info[15:8]), 32'd4);
      rx_claim(3'd0);
      check("R12 rx refused into reserve", 32'(rx_alloc_ok), 32'd0);
      check("R12 refused keeps free", 32'(mem_info[15:8]), 32'd4);
      cmd(16'h0023, 7'd0);
      check("R12 host uses reserve", 32'(alloc_result), 32'h02);
      check("R12 free 0", 32'(mem_info[15:8]), 32'd0);

      // R9: drop without freeing, then drop with freeing
      cmd(16'h0060, 7'd0);
      check("R9 head advanced", 32'(queue_heads), 32'h0180);
      check("R9 drop keeps pages", 32'(mem_info[15:8]), 32'd0);
      cmd(16'h0080, 7'd0);
      check("R7 busy after hand-back", 32'(busy), 32'd1);
      cmd(16'h0020, 7'd0);
      rx_claim(3'd0);
      check("R7 rx refused while busy", 32'(rx_alloc_ok), 32'd0);
      wait_idle(n);
      check("R7 claim ignored while busy", 32'(alloc_result), 32'h02);
      check("R9 freed head pages", 32'(mem_info[15:8]), 32'd4);
      check("R9 rx queue empty", 32'(queue_heads), 32'h8080);

      // R7: busy length
      cmd(16'h00A0, 7'd0);
      wait_idle(n);
      check("R7 busy cycles", 32'(n), 32'd16);
      check("R7 free after walk", 32'(mem_info[15:8]), 32'd12);

      // R11: wipe during the walk
      cmd(16'h00A0, 7'd2);
      check("R7 busy started", 32'(busy), 32'd1);
      cmd(16'h0040, 7'd0);
      check("R11 wipe drops busy", 32'(busy), 32'd0);
      check("R11 wipe frees all", 32'(mem_info[15:8]), 32'd16);

      // R12: receive request loses to a host command in the same cycle
      rx_req = 1'b1; rx_size_m1 = 3'd0;
      cmd(16'h0020, 7'd0);
      rx_req = 1'b0;
      check("R12 rx loses to host", 32'(rx_alloc_ok), 32'd0);
      check("R2 host wins", 32'(alloc_result), 32'h00);

      finish_run();
   end
endmodule